// File: doc/BRIEF.md
# Stereo Serial-Audio Attenuator Front End

This block takes a two-channel serial PCM stream (bit clock, frame clock and data line), rebuilds a left and a right sample in each frame and scales each one with its own linear gain. It also applies muting and an optional output polarity flip, and it raises a flag after a long run of silence on both channels. All serial inputs are oversampled by one fast system clock, so the bit clock may stop, run in bursts or pause between bits without upsetting the framing. Word boundaries come only from frame-clock transitions.

A three-wire control port (shift clock, latch strobe, data) loads 16-bit words. A word sets the left gain, the right gain, or a mode register that holds the per-channel mutes, the polarity flip and the serial word width. Each frame produces one pair of signed 24-bit samples, marked by a single-cycle valid strobe.

Top module: `stereo_atten`

## Requirements
- R1: Frame clock low carries the left word and high the right word. The bit-clock rise on which a frame-clock change is first seen carries no data, and the MSB follows on the next rise. The bit clock may pause for any number of system cycles between bits. When the last bit of a right word arrives, `out_valid` pulses high for exactly one cycle and both output samples update. This happens once per frame.
- R2: Mode bits [4:3] set the serial word width: 00 is 16 bits, 01 is 20 bits, 10 or 11 is 24 bits. Bits that arrive after the configured width in a channel slot are ignored. The word is left-justified into the 24-bit sample, with the unused low bits set to zero.
- R3: The control port shifts `cdata` in MSB first on each rising edge of `cclk`. The last 16 bits take effect on a rising edge of `clatch`. Bits [15:14] select the target: 00 loads the left gain from bits [13:0], 01 loads the right gain from bits [13:0], 10 loads the mode register from bits [4:0], and 11 changes nothing.
- R4: Each output equals the input sample times its channel's 14-bit gain code, divided by 16384 and rounded toward negative infinity.
- R5: Synchronous active-high reset sets both gain codes to 16383 and sets the mode to 24-bit width, no mutes and no inversion. It also clears the outputs, `out_valid` and `zero_flag`.
- R6: While `mute` is high, both output samples are zero.
- R7: Mode bit 0 forces the left output to zero and mode bit 1 forces the right output to zero.
- R8: Mode bit 2 negates both scaled outputs. A result that cannot be represented saturates to the largest positive value.
- R9: `zero_flag` goes high on the output of the 1025th consecutive frame in which both input samples are zero, and stays high while the silence lasts. It drops on the output of the first frame that has a nonzero input sample on either channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples all serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Serial audio bit clock; data is sampled on its rising edge |
| lrclk | input | 1 | Frame clock; low is left, high is right |
| sdata | input | 1 | Serial audio data, MSB first |
| cclk | input | 1 | Control shift clock |
| clatch | input | 1 | Control latch strobe; a rising edge applies the word |
| cdata | input | 1 | Control serial data, MSB first |
| mute | input | 1 | Forces both outputs to zero while high |
| out_l | output | 24 | Scaled left sample, two's complement |
| out_r | output | 24 | Scaled right sample, two's complement |
| out_valid | output | 1 | One-cycle strobe marking a new output pair |
| zero_flag | output | 1 | High after a long run of silence on both channels |

## Verification
The assertions check on every cycle that the valid strobes last one cycle and that the gain and mode registers change only after a latch strobe. They also check that muting by pin or by mode bit zeroes the next output, that a nonzero input clears the zero flag, and that the flag moves only on a new frame. Other behaviour can only be shown by the bench's scenarios, which compare each output against a reference model: the arithmetic of the gain and its rounding toward negative infinity, left-justification at 16, 20 and 24 bits, discarding of bits past the word width, framing when the bit clock pauses, the ignored register select, the reset defaults, and the exact frame on which the silence flag rises.

// File: rtl/stereo_atten_pkg.sv
package stereo_atten_pkg;
  localparam int SAMPLE_W = 24;
  localparam int GAIN_W   = 14;
  localparam int CWORD_W  = 16;

  typedef enum logic [1:0] {
    SEL_GAIN_L = 2'b00,
    SEL_GAIN_R = 2'b01,
    SEL_MODE   = 2'b10,
    SEL_NONE   = 2'b11
  } sel_e;

  typedef struct packed {
    logic [1:0] wsel;
    logic       inv;
    logic       mute_r;
    logic       mute_l;
  } mode_t;

  localparam mode_t MODE_RESET = '{wsel: 2'b10, inv: 1'b0, mute_r: 1'b0, mute_l: 1'b0};
endpackage

// File: rtl/stereo_atten_rx.sv
module stereo_atten_rx #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk,
  input  logic              lrclk,
  input  logic              sdata,
  input  logic [1:0]        wsel,
  output logic              frame_valid,
  output logic [DATA_W-1:0] left,
  output logic [DATA_W-1:0] right
);
  localparam int CNT_W = $clog2(DATA_W + 1) + 1;

  logic              bclk_q, lr_last, chan, active;
  logic [CNT_W-1:0]  cnt, nbits;
  logic [DATA_W-1:0] shreg, shifted, aligned;
  logic              rise;

  assign rise = bclk & ~bclk_q;

  always_comb begin
    case (wsel)
      2'b00:   nbits = CNT_W'(16);
      2'b01:   nbits = CNT_W'(20);
      default: nbits = CNT_W'(DATA_W);
    endcase
  end

  assign shifted = {shreg[DATA_W-2:0], sdata};
  assign aligned = shifted << (DATA_W - int'(nbits));

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q      <= 1'b0;
      lr_last     <= 1'b1;
      chan        <= 1'b0;
      active      <= 1'b0;
      cnt         <= '0;
      shreg       <= '0;
      left        <= '0;
      right       <= '0;
      frame_valid <= 1'b0;
    end else begin
      bclk_q      <= bclk;
      frame_valid <= 1'b0;
      if (rise) begin
        lr_last <= lrclk;
        if (lrclk != lr_last) begin
          chan   <= lrclk;
          cnt    <= '0;
          active <= 1'b1;
        end else if (active && cnt < nbits) begin
          shreg <= shifted;
          cnt   <= cnt + 1'b1;
          if (cnt == nbits - 1'b1) begin
            if (chan) begin
              right       <= aligned;
              frame_valid <= 1'b1;
            end else begin
              left <= aligned;
            end
          end
        end
      end
    end
  end

  // R1: one frame strobe per completed right word, never two in a row
  assert_frame_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid);
endmodule

// File: rtl/stereo_atten_ctrl.sv
module stereo_atten_ctrl
  import stereo_atten_pkg::*;
#(
  parameter int CW = CWORD_W,
  parameter int GW = GAIN_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cclk,
  input  logic          clatch,
  input  logic          cdata,
  output logic [GW-1:0] gain_l,
  output logic [GW-1:0] gain_r,
  output mode_t         mode
);
  localparam logic [GW-1:0] GAIN_RESET = {GW{1'b1}};

  logic          cclk_q, clatch_q, shift_rise, latch_rise;
  logic [CW-1:0] word;
  sel_e          sel;

  assign shift_rise = cclk & ~cclk_q;
  assign latch_rise = clatch & ~clatch_q;
  assign sel        = sel_e'(word[CW-1:CW-2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cclk_q   <= 1'b0;
      clatch_q <= 1'b0;
      word     <= '0;
      gain_l   <= GAIN_RESET;
      gain_r   <= GAIN_RESET;
      mode     <= MODE_RESET;
    end else begin
      cclk_q   <= cclk;
      clatch_q <= clatch;
      if (shift_rise) word <= {word[CW-2:0], cdata};
      if (latch_rise) begin
        case (sel)
          SEL_GAIN_L: gain_l <= word[GW-1:0];
          SEL_GAIN_R: gain_r <= word[GW-1:0];
          SEL_MODE:   mode   <= mode_t'(word[$bits(mode_t)-1:0]);
          default:    ;
        endcase
      end
    end
  end

  // R3: settings move only in the cycle after a latch strobe
  assert_settings_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(latch_rise) |-> ($stable(gain_l) && $stable(gain_r) && $stable(mode)));
endmodule

// File: rtl/stereo_atten_scale.sv
module stereo_atten_scale
  import stereo_atten_pkg::*;
#(
  parameter int SW          = SAMPLE_W,
  parameter int GW          = GAIN_W,
  parameter int ZERO_FRAMES = 1024
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [SW-1:0] in_l,
  input  logic [SW-1:0] in_r,
  input  logic [GW-1:0] gain_l,
  input  logic [GW-1:0] gain_r,
  input  mode_t         mode,
  input  logic          mute_all,
  output logic [SW-1:0] out_l,
  output logic [SW-1:0] out_r,
  output logic          out_valid,
  output logic          zero_flag
);
  localparam int ZC_W = $clog2(ZERO_FRAMES + 2);
  localparam logic [ZC_W-1:0] LIMIT = ZC_W'(ZERO_FRAMES);
  localparam logic signed [SW-1:0] S_MIN = {1'b1, {(SW-1){1'b0}}};
  localparam logic signed [SW-1:0] S_MAX = {1'b0, {(SW-1){1'b1}}};

  function automatic logic [SW-1:0] scale(input logic signed [SW-1:0] x,
                                          input logic [GW-1:0] g,
                                          input logic inv);
    logic signed [SW+GW:0] prod, shr;
    logic signed [SW-1:0]  r;
    prod = x * $signed({1'b0, g});
    shr  = prod >>> GW;
    r    = shr[SW-1:0];
    if (inv) r = (r == S_MIN) ? S_MAX : -r;
    return r;
  endfunction

  logic [ZC_W-1:0] zcnt, zcnt_next;
  logic            nonzero;

  assign nonzero   = (in_l != '0) || (in_r != '0);
  assign zcnt_next = nonzero ? '0 : ((zcnt > LIMIT) ? zcnt : zcnt + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_l     <= '0;
      out_r     <= '0;
      out_valid <= 1'b0;
      zcnt      <= '0;
      zero_flag <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_l     <= (mute_all || mode.mute_l) ? '0 : scale(in_l, gain_l, mode.inv);
        out_r     <= (mute_all || mode.mute_r) ? '0 : scale(in_r, gain_r, mode.inv);
        zcnt      <= zcnt_next;
        zero_flag <= zcnt_next > LIMIT;
      end
    end
  end

  // R1: output strobe lasts one cycle
  assert_out_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R6: mute pin zeroes both outputs
  assert_mute_pin_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mute_all) |=> (out_l == '0 && out_r == '0));
  // R7: per-channel mute bits zero their channel
  assert_chan_mute_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode.mute_l) |=> (out_l == '0));
  // R9: any nonzero input drops the flag; flag moves only with a frame
  assert_zero_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && nonzero) |=> !zero_flag);
  assert_zero_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> $stable(zero_flag));
endmodule

// File: rtl/stereo_atten.sv
module stereo_atten
  import stereo_atten_pkg::*;
#(
  parameter int SW          = SAMPLE_W,
  parameter int GW          = GAIN_W,
  parameter int CW          = CWORD_W,
  parameter int ZERO_FRAMES = 1024
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bclk,
  input  logic          lrclk,
  input  logic          sdata,
  input  logic          cclk,
  input  logic          clatch,
  input  logic          cdata,
  input  logic          mute,
  output logic [SW-1:0] out_l,
  output logic [SW-1:0] out_r,
  output logic          out_valid,
  output logic          zero_flag
);
  logic          fv;
  logic [SW-1:0] rx_l, rx_r;
  logic [GW-1:0] g_l, g_r;
  mode_t         mode;

  stereo_atten_ctrl #(.CW(CW), .GW(GW)) ctrl_i (
    .clk(clk), .rst(rst), .cclk(cclk), .clatch(clatch), .cdata(cdata),
    .gain_l(g_l), .gain_r(g_r), .mode(mode)
  );

  stereo_atten_rx #(.DATA_W(SW)) rx_i (
    .clk(clk), .rst(rst), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .wsel(mode.wsel), .frame_valid(fv), .left(rx_l), .right(rx_r)
  );

  stereo_atten_scale #(.SW(SW), .GW(GW), .ZERO_FRAMES(ZERO_FRAMES)) scale_i (
    .clk(clk), .rst(rst), .in_valid(fv), .in_l(rx_l), .in_r(rx_r),
    .gain_l(g_l), .gain_r(g_r), .mode(mode), .mute_all(mute),
    .out_l(out_l), .out_r(out_r), .out_valid(out_valid), .zero_flag(zero_flag)
  );
endmodule

// File: tb/stereo_atten_tb_top.sv
module stereo_atten_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk = 1'b0, lrclk = 1'b1, sdata = 1'b0;
  logic cclk = 1'b0, clatch = 1'b0, cdata = 1'b0, mute = 1'b0;
  logic [23:0] out_l, out_r;
  logic out_valid, zero_flag;

  int checks = 0, failures = 0;
  int fi = 0, oi = 0;
  int exp_l[2048], exp_r[2048];
  bit exp_z[2048];
  string tag = "R5";

  int gl, gr, wcode, zc;
  bit m_l, m_r, inv;

  always #10 clk = ~clk;

  stereo_atten dut_i (
    .clk(clk), .rst(rst), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .cclk(cclk), .clatch(clatch), .cdata(cdata), .mute(mute),
    .out_l(out_l), .out_r(out_r), .out_valid(out_valid), .zero_flag(zero_flag)
  );

  task automatic check(input string r, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, expv);
    end
  endtask

  function automatic int width_of(input int c);
    return (c == 0) ? 16 : (c == 1) ? 20 : 24;
  endfunction

  function automatic int align(input int w, input int nb);
    int t;
    t = w << (32 - nb);
    return t >>> 8;
  endfunction

  function automatic int model(input int x, input int g, input bit iv, input bit m);
    longint p;
    p = longint'(x) * g;
    p = p >>> 14;
    if (iv) p = -p;
    if (p > 8388607) p = 8388607;
    if (m) p = 0;
    return int'(p);
  endfunction

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      check(tag, "out_l", int'($signed(out_l)), exp_l[oi]);
      check(tag, "out_r", int'($signed(out_r)), exp_r[oi]);
      check((tag == "R9") ? "R9" : tag, "zero_flag", int'(zero_flag), int'(exp_z[oi]));
      oi++;
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    gl = 16383; gr = 16383; wcode = 2; m_l = 0; m_r = 0; inv = 0; zc = 0;
    fi = 0; oi = 0;
    @(negedge clk);
  endtask

  task automatic ctrl_write(input int sel, input int val);
    logic [15:0] wd;
    wd = {sel[1:0], val[13:0]};
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk); cclk = 1'b0; cdata = wd[i];
      @(negedge clk); cclk = 1'b1;
    end
    @(negedge clk); cclk = 1'b0; clatch = 1'b1;
    @(negedge clk); clatch = 1'b0;
    @(negedge clk);
    if (sel == 0) gl = val & 16'h3FFF;
    else if (sel == 1) gr = val & 16'h3FFF;
    else if (sel == 2) begin
      m_l = val[0]; m_r = val[1]; inv = val[2]; wcode = (val >> 3) & 3;
    end
  endtask

  task automatic send_half(input bit ch, input int w, input int nb, input bit gaps);
    bit b;
    for (int s = 0; s < 25; s++) begin
      if (s == 0) b = $urandom % 2;
      else if (s <= nb) b = w[nb - s];
      else b = 1'b1;
      @(negedge clk); bclk = 1'b0; lrclk = ch; sdata = b;
      if (gaps) repeat ($urandom % 3) @(negedge clk);
      @(negedge clk); bclk = 1'b1;
    end
  endtask

  task automatic send_frame(input int wl, input int wr, input bit gaps);
    int nb, xl, xr;
    nb = width_of(wcode);
    wl = wl & ((nb == 32) ? -1 : ((1 << nb) - 1));
    wr = wr & ((1 << nb) - 1);
    xl = align(wl, nb);
    xr = align(wr, nb);
    exp_l[fi] = model(xl, gl, inv, mute | m_l);
    exp_r[fi] = model(xr, gr, inv, mute | m_r);
    if (xl == 0 && xr == 0) begin
      if (zc <= 1024) zc++;
    end else zc = 0;
    exp_z[fi] = (zc > 1024);
    fi++;
    send_half(1'b0, wl, nb, gaps);
    send_half(1'b1, wr, nb, gaps);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h1234_5A5A);
    repeat (2) @(negedge clk);
    do_reset();
    // R5: reset state at the ports
    check("R5", "out_valid after reset", int'(out_valid), 0);
    check("R5", "zero_flag after reset", int'(zero_flag), 0);
    check("R5", "out_l after reset", int'(out_l), 0);

    // R4 / R5: default gain 16383 on random 24-bit data
    tag = "R4";
    for (int i = 0; i < 8; i++) send_frame($urandom, $urandom, 1'b0);
    // R4 rounding corners
    send_frame(24'hFFFFFF, 24'h000001, 1'b0);
    ctrl_write(0, 1); ctrl_write(1, 0);
    send_frame(24'hFFFFFF, 24'h800000, 1'b0);
    send_frame(24'h800000, 24'h7FFFFF, 1'b0);
    ctrl_write(0, 8192); ctrl_write(1, 12345);
    for (int i = 0; i < 6; i++) send_frame($urandom, $urandom, 1'b0);

    // R1: paused bit clock
    tag = "R1";
    for (int i = 0; i < 5; i++) send_frame($urandom, $urandom, 1'b1);

    // R2: 16- and 20-bit words, padding bits driven high
    tag = "R2";
    ctrl_write(2, 0 << 3);
    for (int i = 0; i < 4; i++) send_frame($urandom, $urandom, 1'b0);
    send_frame(16'h8000, 16'h7FFF, 1'b0);
    ctrl_write(2, 1 << 3);
    for (int i = 0; i < 4; i++) send_frame($urandom, $urandom, 1'b1);
    ctrl_write(2, 3 << 3);
    send_frame($urandom, $urandom, 1'b0);

    // R3: select 11 changes nothing; random gain loads
    tag = "R3";
    ctrl_write(3, 16'h3FFF);
    send_frame($urandom, $urandom, 1'b0);
    for (int i = 0; i < 4; i++) begin
      ctrl_write(0, $urandom % 16384);
      ctrl_write(1, $urandom % 16384);
      send_frame($urandom, $urandom, 1'b0);
    end

    // R8: inversion, including most negative input at full gain
    tag = "R8";
    ctrl_write(0, 16383); ctrl_write(1, 16383);
    ctrl_write(2, (2 << 3) | 4);
    send_frame(24'h800000, 24'h7FFFFF, 1'b0);
    for (int i = 0; i < 3; i++) send_frame($urandom, $urandom, 1'b0);

    // R7: per-channel mutes
    tag = "R7";
    ctrl_write(2, (2 << 3) | 1);
    send_frame($urandom | 1, $urandom | 1, 1'b0);
    ctrl_write(2, (2 << 3) | 2);
    send_frame($urandom | 1, $urandom | 1, 1'b0);

    // R6: mute pin
    tag = "R6";
    ctrl_write(2, 2 << 3);
    mute = 1'b1;
    send_frame($urandom | 1, $urandom | 1, 1'b0);
    send_frame(24'h7FFFFF, 24'h800000, 1'b0);
    mute = 1'b0;
    send_frame($urandom | 1, $urandom | 1, 1'b0);

    // R5: defaults return after reset
    tag = "R5";
    ctrl_write(0, 5); ctrl_write(2, (0 << 3) | 4);
    do_reset();
    send_frame(24'h400000, 24'hC00000, 1'b0);
    send_frame($urandom, $urandom, 1'b0);

    // R9: long silence, interrupted run, then flag drop
    tag = "R9";
    for (int i = 0; i < 10; i++) send_frame(0, 0, 1'b0);
    send_frame(0, 1, 1'b0);
    for (int i = 0; i < 1026; i++) send_frame(0, 0, 1'b0);
    send_frame(1, 0, 1'b0);
    send_frame(0, 0, 1'b0);

    repeat (10) @(negedge clk);
    check("R1", "output frame count", oi, fi);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule